// File: doc/BRIEF.md
# Presettable Time-of-Day Accumulator

This block keeps an hours-minutes-seconds count in six BCD digits and advances it by one second on every strobe from a one-pulse-per-second source. The hour field does not have to roll over at 24: a BCD recycle value chooses a wrap point anywhere from 1 to 99 hours. When the count would reach that hour, every digit returns to zero. All six digits are driven in parallel on one bus, for display and for logging.

A host can load or step any single digit. The digit it selects changes within its own range and never carries into a neighbour. This adjustment can happen in the same clock as a tick, and the tick still advances every digit that is not selected. The block has one register stage. A tick or host command that is present at a rising clock edge shows on `digits_o` after that edge.

Top module: `tod_accum`

## Requirements
- R1: While `rst_n` is low, and after it is released with no tick or command, `digits_o` reads 00:00:00.
- R2: A tick with no host command advances the count by one second. The seconds and minutes units count 0 to 9 and carry into their tens, which count 0 to 5. Minutes tens carries into hours units (0 to 9), and hours units carries into hours tens (0 to 9).
- R3: A tick at HH:59:59, where HH+1 reaches the recycle value `wrap_i`, clears all six digits to 00:00:00.
- R4: A recycle value of 8'h00, or a value with either nibble above 9, behaves as 99. A value of 8'h01 makes 00:59:59 clear to 00:00:00.
- R5: Command 1 (write) loads `wdata_i` into the digit chosen by `sel_i` when `wdata_i` is below that digit's modulus. The other digits do not change and no carry occurs.
- R6: A write whose value is not below the selected digit's modulus leaves that digit as it was (the digit follows the tick, if there is one).
- R7: Command 2 (step) adds one to the selected digit and wraps it within its own modulus (5 to 0 for a tens digit of minutes or seconds, 9 to 0 otherwise) with no carry out.
- R8: When a tick and a command to digit k fall in the same cycle, digit k takes the host result. Every other digit follows the tick, including any carry that digit k's old value would have produced.
- R9: Commands 0 and 3, and `sel_i` values 6 and 7, have no effect on the count.
- R10: Digit k sits at `digits_o[4k+3:4k]`: k=0 seconds units, 1 seconds tens, 2 minutes units, 3 minutes tens, 4 hours units, 5 hours tens. The bus reads as HHMMSS in hexadecimal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe, one per second |
| sel_i | input | 3 | Digit index 0..5 for host commands |
| cmd_i | input | 2 | 0 idle, 1 write, 2 step, 3 idle |
| wdata_i | input | 4 | BCD value for a write |
| wrap_i | input | 8 | BCD recycle hour count |
| digits_o | output | 24 | Six BCD digits, HH MM SS |

## Verification
A master tick and a host adjustment can arrive in the same clock. The bench provokes this by stepping the seconds tens digit together with a tick. It also writes the seconds units digit on the tick that turns 01:59:59 over, so the digit being overwritten is the one that starts the carry chain. The expected bus value has the host's digit in place and the tick's full ripple in every other digit. The check confirms that the command neither swallows the tick nor lets its own value carry.

// File: rtl/tod_pkg.sv
package tod_pkg;
   localparam int unsigned NDIG = 6;

   typedef enum logic [1:0] {
      CMD_IDLE  = 2'd0,
      CMD_WRITE = 2'd1,
      CMD_STEP  = 2'd2,
      CMD_RSVD  = 2'd3
   } host_cmd_e;

   // tens of seconds and tens of minutes are base 6, all else base 10
   function automatic int unsigned digit_mod(input int unsigned k);
      return (k == 1 || k == 3) ? 6 : 10;
   endfunction
endpackage

// File: rtl/tod_digit_cell.sv
module tod_digit_cell #(
   parameter int unsigned DW  = 4,
   parameter int unsigned MOD = 10
) (
   input  logic [DW-1:0] cur_i,
   input  logic          inc_i,
   input  logic          clr_i,
   input  logic          hit_i,
   input  logic [1:0]    cmd_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] nxt_o,
   output logic          cout_o
);
   import tod_pkg::*;

   localparam logic [DW-1:0] TOP = DW'(MOD - 1);
   localparam logic [DW-1:0] LIM = DW'(MOD);

   logic          at_top;
   logic [DW-1:0] stepped;
   logic [DW-1:0] tick_val;
   logic [DW-1:0] host_val;

   assign at_top  = (cur_i == TOP);
   assign stepped = at_top ? '0 : cur_i + 1'b1;
   assign cout_o  = inc_i & at_top;

   always_comb begin
      if (clr_i)      tick_val = '0;
      else if (inc_i) tick_val = stepped;
      else            tick_val = cur_i;
   end

   always_comb begin
      unique case (host_cmd_e'(cmd_i))
         CMD_WRITE: host_val = (wdata_i < LIM) ? wdata_i : tick_val;
         CMD_STEP:  host_val = stepped;
         default:   host_val = tick_val;
      endcase
   end

   assign nxt_o = hit_i ? host_val : tick_val;
endmodule

// File: rtl/tod_hour_wrap.sv
module tod_hour_wrap #(
   parameter int unsigned DW      = 4,
   parameter int unsigned MAX_HRS = 99
) (
   input  logic [2*DW-1:0] wrap_i,
   input  logic [DW-1:0]   hr_tens_i,
   input  logic [DW-1:0]   hr_units_i,
   output logic            wrap_o
);
   localparam int unsigned VW = $clog2(MAX_HRS + 2);

   logic          bcd_ok;
   logic [VW-1:0] lim;
   logic [VW-1:0] next_hr;

   assign bcd_ok = (wrap_i[2*DW-1:DW] <= DW'(9)) && (wrap_i[DW-1:0] <= DW'(9))
                   && (wrap_i != '0);

   always_comb begin
      if (bcd_ok) lim = VW'(wrap_i[2*DW-1:DW]) * VW'(10) + VW'(wrap_i[DW-1:0]);
      else        lim = VW'(MAX_HRS);
   end

   assign next_hr = VW'(hr_tens_i) * VW'(10) + VW'(hr_units_i) + VW'(1);
   assign wrap_o  = (next_hr >= lim);
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
   parameter int unsigned DW = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick_i,
   input  logic [$clog2(tod_pkg::NDIG)-1:0] sel_i,
   input  logic [1:0]                    cmd_i,
   input  logic [DW-1:0]                 wdata_i,
   input  logic [2*DW-1:0]               wrap_i,
   output logic [tod_pkg::NDIG*DW-1:0]   digits_o
);
   import tod_pkg::*;

   localparam int unsigned SEL_W   = $clog2(NDIG);
   localparam int unsigned MIN_TEN = 3;
   localparam int unsigned HR_UNI  = 4;
   localparam int unsigned HR_TEN  = 5;

   if (DW < 4) begin : g_bad_width
      $error("tod_accum: DW must hold one BCD digit");
   end

   logic [DW-1:0] q   [NDIG];
   logic [DW-1:0] nxt [NDIG];
   logic [NDIG:0] inc;
   logic [NDIG-1:0] cout;
   logic          hr_wrap;
   logic          clr_all;

   assign inc[0] = tick_i;

   tod_hour_wrap #(.DW(DW), .MAX_HRS(99)) u_wrap (
      .wrap_i     (wrap_i),
      .hr_tens_i  (q[HR_TEN]),
      .hr_units_i (q[HR_UNI]),
      .wrap_o     (hr_wrap)
   );

   // carry out of minutes tens only occurs on a tick at xx:59:59
   assign clr_all = cout[MIN_TEN] & hr_wrap;

   for (genvar k = 0; k < NDIG; k++) begin : g_dig
      tod_digit_cell #(.DW(DW), .MOD(digit_mod(k))) u_cell (
         .cur_i   (q[k]),
         .inc_i   (inc[k]),
         .clr_i   (clr_all),
         .hit_i   (sel_i == SEL_W'(k)),
         .cmd_i   (cmd_i),
         .wdata_i (wdata_i),
         .nxt_o   (nxt[k]),
         .cout_o  (cout[k])
      );
      assign inc[k+1] = cout[k];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[k] <= '0;
         else        q[k] <= nxt[k];
      end

      assign digits_o[k*DW +: DW] = q[k];
   end
endmodule

// File: rtl/tod_accum_chk.sv
module tod_accum_chk #(
   parameter int unsigned DW = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            tick_i,
   input logic [2:0]      sel_i,
   input logic [1:0]      cmd_i,
   input logic [DW-1:0]   wdata_i,
   input logic [2*DW-1:0] wrap_i,
   input logic [6*DW-1:0] digits_o
);
   logic       host_act;
   logic       lim_ok;
   int unsigned lim;
   int unsigned hrs;

   assign host_act = (cmd_i == 2'd1 || cmd_i == 2'd2) && (sel_i < 3'd6);
   assign lim_ok   = wrap_i[7:4] < 4'd10 && wrap_i[3:0] < 4'd10 && wrap_i != 8'h00;
   assign lim      = lim_ok ? (32'(wrap_i[7:4]) * 10 + 32'(wrap_i[3:0])) : 99;
   assign hrs      = 32'(digits_o[23:20]) * 10 + 32'(digits_o[19:16]);

   AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      digits_o[3:0] < 4'd10 && digits_o[7:4] < 4'd6 && digits_o[11:8] < 4'd10 &&
      digits_o[15:12] < 4'd6 && digits_o[19:16] < 4'd10 && digits_o[23:20] < 4'd10); // R2

   AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !host_act && digits_o[3:0] < 4'd9)
      |=> digits_o[3:0] == $past(digits_o[3:0]) + 4'd1); // R2

   AST_WRAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !host_act && digits_o[15:0] == 16'h5959 && hrs + 1 >= lim)
      |=> digits_o == '0); // R3

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !host_act) |=> $stable(digits_o)); // R9

   AST_STEP_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && cmd_i == 2'd2 && sel_i == 3'd3 && digits_o[15:12] == 4'd5)
      |=> digits_o[15:12] == 4'd0 && digits_o[19:16] == $past(digits_o[19:16])); // R7
endmodule

bind tod_accum tod_accum_chk #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_i   (tick_i),
   .sel_i    (sel_i),
   .cmd_i    (cmd_i),
   .wdata_i  (wdata_i),
   .wrap_i   (wrap_i),
   .digits_o (digits_o)
);

// File: tb/sim_tod_accum.sv
module sim_tod_accum;
   localparam time CLK_PER = 10ns;
   localparam int  NV      = 59;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        tick_i;
   logic [2:0]  sel_i;
   logic [1:0]  cmd_i;
   logic [3:0]  wdata_i;
   logic [7:0]  wrap_i;
   logic [23:0] digits_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PER/2) clk = ~clk;

   tod_accum u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sel_i(sel_i),
      .cmd_i(cmd_i), .wdata_i(wdata_i), .wrap_i(wrap_i), .digits_o(digits_o)
   );

   // {tick, sel, cmd, wdata, wrap, expected HHMMSS, requirement number}
   localparam logic [45:0] VEC [NV] = '{
      {1'b1,3'd0,2'd0,4'h0,8'h99,24'h000001,4'd2},  // R2
      {1'b0,3'd0,2'd1,4'h9,8'h99,24'h000009,4'd5},  // R5
      {1'b1,3'd0,2'd0,4'h0,8'h99,24'h000010,4'd2},  // R2 units carry
      {1'b0,3'd1,2'd1,4'h5,8'h99,24'h000050,4'd5},
      {1'b0,3'd0,2'd1,4'h9,8'h99,24'h000059,4'd5},
      {1'b1,3'd0,2'd0,4'h0,8'h99,24'h000100,4'd2},  // R2 into minutes
      {1'b0,3'd3,2'd1,4'h5,8'h99,24'h005100,4'd5},
      {1'b0,3'd2,2'd1,4'h9,8'h99,24'h005900,4'd5},
      {1'b0,3'd1,2'd1,4'h5,8'h99,24'h005950,4'd5},
      {1'b0,3'd0,2'd1,4'h9,8'h99,24'h005959,4'd5},
      {1'b1,3'd0,2'd0,4'h0,8'h99,24'h010000,4'd2},  // R2 into hours
      {1'b0,3'd1,2'd2,4'h0,8'h99,24'h010010,4'd7},  // R7
      {1'b0,3'd1,2'd1,4'h7,8'h99,24'h010010,4'd6},  // R6 seven in base 6
      {1'b0,3'd0,2'd1,4'hA,8'h99,24'h010010,4'd6},  // R6
      {1'b0,3'd6,2'd1,4'h3,8'h99,24'h010010,4'd9},  // R9 bad select
      {1'b0,3'd0,2'd3,4'h3,8'h99,24'h010010,4'd9},  // R9 reserved cmd
      {1'b0,3'd7,2'd2,4'h0,8'h99,24'h010010,4'd9},
      {1'b1,3'd1,2'd2,4'h0,8'h99,24'h010021,4'd8},  // R8 tick + step
      {1'b0,3'd0,2'd1,4'h9,8'h99,24'h010029,4'd5},
      {1'b0,3'd1,2'd1,4'h5,8'h99,24'h010059,4'd5},
      {1'b0,3'd2,2'd1,4'h9,8'h99,24'h010959,4'd5},
      {1'b0,3'd3,2'd1,4'h5,8'h99,24'h015959,4'd5},
      {1'b1,3'd0,2'd0,4'h0,8'h02,24'h000000,4'd3},  // R3 wrap at 2 h
      {1'b0,3'd4,2'd1,4'h1,8'h99,24'h010000,4'd5},
      {1'b0,3'd3,2'd1,4'h5,8'h99,24'h015000,4'd5},
      {1'b0,3'd2,2'd1,4'h9,8'h99,24'h015900,4'd5},
      {1'b0,3'd1,2'd1,4'h5,8'h99,24'h015950,4'd5},
      {1'b0,3'd0,2'd1,4'h9,8'h99,24'h015959,4'd5},
      {1'b1,3'd0,2'd1,4'h3,8'h99,24'h020003,4'd8},  // R8 write + full ripple
      {1'b0,3'd3,2'd1,4'h5,8'h99,24'h025003,4'd5},
      {1'b0,3'd3,2'd2,4'h0,8'h99,24'h020003,4'd7},  // R7 5 -> 0, no carry
      {1'b0,3'd5,2'd2,4'h0,8'h99,24'h120003,4'd7},
      {1'b0,3'd5,2'd1,4'h9,8'h99,24'h920003,4'd5},
      {1'b0,3'd5,2'd2,4'h0,8'h99,24'h020003,4'd7},  // R7 9 -> 0
      {1'b0,3'd5,2'd1,4'h9,8'h3A,24'h920003,4'd5},
      {1'b0,3'd4,2'd1,4'h8,8'h3A,24'h980003,4'd5},
      {1'b0,3'd3,2'd1,4'h5,8'h3A,24'h985003,4'd5},
      {1'b0,3'd2,2'd1,4'h9,8'h3A,24'h985903,4'd5},
      {1'b0,3'd1,2'd1,4'h5,8'h3A,24'h985953,4'd5},
      {1'b0,3'd0,2'd1,4'h9,8'h3A,24'h985959,4'd5},
      {1'b1,3'd0,2'd0,4'h0,8'h3A,24'h000000,4'd4},  // R4 invalid BCD -> 99
      {1'b0,3'd1,2'd1,4'h5,8'h01,24'h000050,4'd5},
      {1'b0,3'd0,2'd1,4'h9,8'h01,24'h000059,4'd5},
      {1'b0,3'd3,2'd1,4'h5,8'h01,24'h005059,4'd5},
      {1'b0,3'd2,2'd1,4'h9,8'h01,24'h005959,4'd5},
      {1'b1,3'd0,2'd0,4'h0,8'h01,24'h000000,4'd4},  // R4 limit of one hour
      {1'b0,3'd5,2'd1,4'h9,8'h00,24'h900000,4'd5},
      {1'b0,3'd4,2'd1,4'h8,8'h00,24'h980000,4'd5},
      {1'b0,3'd3,2'd1,4'h5,8'h00,24'h985000,4'd5},
      {1'b0,3'd2,2'd1,4'h9,8'h00,24'h985900,4'd5},
      {1'b0,3'd1,2'd1,4'h5,8'h00,24'h985950,4'd5},
      {1'b0,3'd0,2'd1,4'h9,8'h00,24'h985959,4'd5},
      {1'b1,3'd0,2'd0,4'h0,8'h00,24'h000000,4'd4},  // R4 zero -> 99
      {1'b0,3'd4,2'd1,4'h9,8'h99,24'h090000,4'd5},
      {1'b0,3'd3,2'd1,4'h5,8'h99,24'h095000,4'd5},
      {1'b0,3'd2,2'd1,4'h9,8'h99,24'h095900,4'd5},
      {1'b0,3'd1,2'd1,4'h5,8'h99,24'h095950,4'd5},
      {1'b0,3'd0,2'd1,4'h9,8'h99,24'h095959,4'd5},
      {1'b1,3'd0,2'd0,4'h0,8'h99,24'h100000,4'd2}   // R2 hours tens carry
   };

   task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      tick_i = 1'b0; sel_i = 3'd0; cmd_i = 2'd0; wdata_i = 4'd0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle();
      wrap_i = 8'h99;
      rst_n  = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 in reset", digits_o, 24'h000000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", digits_o, 24'h000000);

      for (int i = 0; i < NV; i++) begin
         logic [45:0] v;
         v = VEC[i];
         {tick_i, sel_i, cmd_i, wdata_i, wrap_i} = v[45:28];
         @(negedge clk);
         idle();
         check($sformatf("R%0d vector %0d", v[3:0], i), digits_o, v[27:4]);
      end

      // R10: digit positions on the bus
      wrap_i = 8'h99;
      sel_i = 3'd5; cmd_i = 2'd1; wdata_i = 4'd3;
      @(negedge clk);
      idle();
      check("R10 hours tens field", {20'h0, digits_o[23:20]}, 24'h3);
      check("R10 seconds units field", {20'h0, digits_o[3:0]}, 24'h0);

      // R9: idle cycles hold the count
      repeat (3) @(negedge clk);
      check("R9 idle hold", digits_o, 24'h300000);

      // R3: wrap at 12 hours from 11:59:59
      wrap_i = 8'h12;
      sel_i = 3'd5; cmd_i = 2'd1; wdata_i = 4'd1; @(negedge clk);
      sel_i = 3'd4; wdata_i = 4'd1; @(negedge clk);
      sel_i = 3'd3; wdata_i = 4'd5; @(negedge clk);
      sel_i = 3'd2; wdata_i = 4'd9; @(negedge clk);
      sel_i = 3'd1; wdata_i = 4'd5; @(negedge clk);
      sel_i = 3'd0; wdata_i = 4'd9; @(negedge clk);
      idle();
      check("R3 preload", digits_o, 24'h115959);
      tick_i = 1'b1; @(negedge clk); idle();
      check("R3 wrap at 12", digits_o, 24'h000000);

      // R1: reset mid-count
      tick_i = 1'b1; @(negedge clk); idle();
      rst_n = 1'b0; @(negedge clk);
      check("R1 mid-run reset", digits_o, 24'h000000);
      rst_n = 1'b1; @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule